// File: doc/BRIEF.md
# Overlay RAM Card Controller

This block sits beside a CPU and controls a 16 KB RAM expansion that can be laid over the ROM in the top of the address space, from 0xD000 to 0xFFFF. Software changes the overlay's mode by touching a 16-address control window at 0xC080 to 0xC08F. A touch can be a read or a write, and the data value does not matter. The block keeps three pieces of mode state: whether overlay reads come from RAM, whether overlay writes reach RAM, and which of two 4 KB banks appears at 0xD000 to 0xDFFF. The 8 KB from 0xE000 to 0xFFFF is a single fixed region.

Writes to the RAM are guarded against accidental arming. Write enable turns on only after two read accesses in a row to an odd control address. Any write access to the control window clears that count. Every CPU access is described by an address, a read/write flag and an access-valid strobe. The outputs are combinational decodes of the current access against the registered mode state. The mode state changes on the clock edge that ends a valid control access. The interface has no data stream and no back-pressure: each valid cycle is one complete access.

Top module: `ovl_ram_ctrl`

## Requirements
- R1: After reset, overlay reads are served by ROM, overlay writes are dropped, the arm count is zero and the 0xD000 bank is bank 2.
- R2: A valid access with address 0xC080 to 0xC08F raises `ctl_hit` in the same cycle, which tells the system to return 0x00 on the data bus. No other address raises it.
- R3: Every valid control access loads the 0xD000 bank from address bit 3: 1 selects bank 1 and 0 selects bank 2.
- R4: A control access with address bits [1:0] = 00, read or write, turns RAM read on, turns RAM write off and clears the arm count.
- R5: The arm count saturates at 2. Further qualifying reads leave it at 2 and keep write enabled.
- R6: A control read with address bit 0 set increments the arm count, and write turns on when the count reaches 2. Bit 1 of that address sets RAM read: 1 turns it on and 0 turns it off.
- R7: A control write with address bit 0 set clears the arm count and sets RAM read from bit 1. It leaves write enable unchanged.
- R8: A control access with address bits [1:0] = 10 turns RAM read and RAM write off and clears the arm count.
- R9: A valid overlay read asserts `ram_sel` when RAM read is on, and asserts `rom_sel` otherwise.
- R10: A valid overlay write asserts `ram_sel` and `ram_we` only when RAM write is on. Otherwise the write is dropped and all selects stay low.
- R11: The RAM address for 0xD000 to 0xDFFF is the offset from 0xD000, with 0x1000 added for bank 2. For 0xE000 to 0xFFFF it is 0x2000 plus the offset from 0xE000. `ram_addr` is 0 whenever `ram_sel` is low.
- R12: Accesses with `acc_vld` low, and accesses outside the control window, leave the mode state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_vld | input | 1 | The current cycle carries a CPU access |
| rnw | input | 1 | 1 = read, 0 = write |
| addr | input | 16 | CPU address |
| ctl_hit | output | 1 | Control window access; the block answers with 0x00 |
| ram_sel | output | 1 | Overlay RAM selected |
| ram_we | output | 1 | Overlay RAM write strobe |
| rom_sel | output | 1 | ROM selected for an overlay read |
| ram_addr | output | 14 | Address into the 16 KB RAM |

## Verification
The bench goes after the arming sequence. A single odd read must not arm writes, and a design that armed on the first read would let a stray write corrupt RAM. A control write placed between two odd reads must reset the count, and a design that only ignored the write would arm one read too early. Saturation is exercised with long runs of odd reads: a wrapping counter would drop write enable. Bank-2 against bank-1 addressing and the fixed upper region are checked through `ram_addr`. A swapped bank or a wrong offset would make the two banks alias. Accesses with `acc_vld` low are probed afterwards through the selects, and a design that decoded them would change mode.

// File: rtl/ovl_pkg.sv
`timescale 1ns/1ps
package ovl_pkg;
  // Control operation, taken from the low two address bits of a window access
  typedef enum logic [1:0] {
    OP_RDON_CLR  = 2'b00,
    OP_CNT_RDOFF = 2'b01,
    OP_ALL_OFF   = 2'b10,
    OP_CNT_RDON  = 2'b11
  } ctl_op_e;

  typedef struct packed {
    logic rd_en;
    logic wr_en;
    logic bank1;
  } ovl_state_t;
endpackage

// File: rtl/ovl_ctl_decode.sv
`timescale 1ns/1ps
module ovl_ctl_decode #(
  parameter int AW = 16,
  parameter logic [AW-1:0] CTL_BASE = 16'hC080
) (
  input  logic [AW-1:0]      addr,
  input  logic               acc_vld,
  input  logic               rnw,
  output logic               hit,
  output ovl_pkg::ctl_op_e   op,
  output logic               bank1_sel,
  output logic               is_rd
);
  logic unused_b2;

  // The window is 16 addresses, aligned to 16
  assign hit       = acc_vld && (addr[AW-1:4] == CTL_BASE[AW-1:4]);
  assign op        = ovl_pkg::ctl_op_e'(addr[1:0]);
  assign bank1_sel = addr[3];
  assign is_rd     = rnw;
  assign unused_b2 = addr[2];
endmodule

// File: rtl/ovl_mode_regs.sv
`timescale 1ns/1ps
module ovl_mode_regs #(
  parameter int ARM = 2,
  parameter int CW  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hit,
  input  ovl_pkg::ctl_op_e    op,
  input  logic                bank1_sel,
  input  logic                is_rd,
  output ovl_pkg::ovl_state_t st,
  output logic [CW-1:0]       cnt
);
  import ovl_pkg::*;

  localparam logic [CW-1:0] ARM_V = CW'(ARM);

  ovl_state_t      st_n;
  logic [CW-1:0]   cnt_n;
  logic [CW-1:0]   cnt_inc;

  // Saturating increment
  assign cnt_inc = (cnt == ARM_V) ? cnt : cnt + 1'b1;

  always_comb begin
    st_n  = st;
    cnt_n = cnt;
    if (hit) begin
      st_n.bank1 = bank1_sel;
      unique case (op)
        OP_RDON_CLR: begin
          st_n.rd_en = 1'b1;
          st_n.wr_en = 1'b0;
          cnt_n      = '0;
        end
        OP_ALL_OFF: begin
          st_n.rd_en = 1'b0;
          st_n.wr_en = 1'b0;
          cnt_n      = '0;
        end
        OP_CNT_RDOFF, OP_CNT_RDON: begin
          st_n.rd_en = (op == OP_CNT_RDON);
          if (is_rd) begin
            cnt_n = cnt_inc;
            if (cnt_inc == ARM_V) st_n.wr_en = 1'b1;
          end else begin
            cnt_n = '0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= '{rd_en: 1'b0, wr_en: 1'b0, bank1: 1'b0};
      cnt <= '0;
    end else begin
      st  <= st_n;
      cnt <= cnt_n;
    end
  end
endmodule

// File: rtl/ovl_addr_map.sv
`timescale 1ns/1ps
module ovl_addr_map #(
  parameter int AW  = 16,
  parameter int RAW = 14,
  parameter logic [AW-1:0] OVL_BASE = 16'hD000,
  parameter logic [AW-1:0] HI_BASE  = 16'hE000
) (
  input  logic                addr_vld,
  input  logic [AW-1:0]       addr,
  input  logic                rnw,
  input  ovl_pkg::ovl_state_t st,
  output logic                ram_sel,
  output logic                ram_we,
  output logic                rom_sel,
  output logic [RAW-1:0]      ram_addr
);
  localparam int BANK = int'(HI_BASE) - int'(OVL_BASE);

  logic          in_ovl, in_hi;
  logic [AW-1:0] lo_off, hi_off;
  logic [RAW-1:0] phys;

  assign in_ovl = addr_vld && (addr >= OVL_BASE);
  assign in_hi  = addr >= HI_BASE;
  assign lo_off = addr - OVL_BASE;
  assign hi_off = addr - HI_BASE;

  // Bank 1 at 0, bank 2 after it, the upper region after both
  always_comb begin
    if (in_hi)
      phys = RAW'(hi_off) + RAW'(2 * BANK);
    else if (st.bank1)
      phys = RAW'(lo_off);
    else
      phys = RAW'(lo_off) + RAW'(BANK);
  end

  assign ram_sel  = in_ovl && (rnw ? st.rd_en : st.wr_en);
  assign ram_we   = in_ovl && !rnw && st.wr_en;
  assign rom_sel  = in_ovl && rnw && !st.rd_en;
  assign ram_addr = ram_sel ? phys : '0;
endmodule

// File: rtl/ovl_ram_ctrl.sv
`timescale 1ns/1ps
module ovl_ram_ctrl #(
  parameter int AW  = 16,
  parameter int RAW = 14,
  parameter int ARM = 2,
  parameter logic [AW-1:0] CTL_BASE = 16'hC080,
  parameter logic [AW-1:0] OVL_BASE = 16'hD000,
  parameter logic [AW-1:0] HI_BASE  = 16'hE000
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           acc_vld,
  input  logic           rnw,
  input  logic [AW-1:0]  addr,
  output logic           ctl_hit,
  output logic           ram_sel,
  output logic           ram_we,
  output logic           rom_sel,
  output logic [RAW-1:0] ram_addr
);
  localparam int CW = $clog2(ARM + 1);

  ovl_pkg::ctl_op_e    op;
  ovl_pkg::ovl_state_t st;
  logic                bank1_sel;
  logic                is_rd;
  logic [CW-1:0]       cnt;

  ovl_ctl_decode #(.AW(AW), .CTL_BASE(CTL_BASE)) u_dec (
    .addr(addr), .acc_vld(acc_vld), .rnw(rnw),
    .hit(ctl_hit), .op(op), .bank1_sel(bank1_sel), .is_rd(is_rd)
  );

  ovl_mode_regs #(.ARM(ARM), .CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n), .hit(ctl_hit), .op(op),
    .bank1_sel(bank1_sel), .is_rd(is_rd), .st(st), .cnt(cnt)
  );

  ovl_addr_map #(.AW(AW), .RAW(RAW), .OVL_BASE(OVL_BASE), .HI_BASE(HI_BASE)) u_map (
    .addr_vld(acc_vld), .addr(addr), .rnw(rnw), .st(st),
    .ram_sel(ram_sel), .ram_we(ram_we), .rom_sel(rom_sel), .ram_addr(ram_addr)
  );
endmodule

// File: rtl/ovl_ram_ctrl_chk.sv
`timescale 1ns/1ps
module ovl_ram_ctrl_chk #(
  parameter int ARM = 2,
  parameter int CW  = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rnw,
  input logic [1:0]    lo2,
  input logic          ctl_hit,
  input logic          ram_sel,
  input logic          ram_we,
  input logic          rom_sel,
  input logic          rd_en,
  input logic          wr_en,
  input logic [CW-1:0] cnt
);
  a_r9_rom_excl: assert property (@(posedge clk) disable iff (!rst_n)
    rom_sel |-> (!rd_en && !ram_sel));

  a_r10_we_armed: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (wr_en && ram_sel && !rnw));

  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(ARM));

  a_r7_wr_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_hit && !rnw) |=> (cnt == '0));

  a_r6_arms: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_hit && rnw && lo2[0] && cnt == CW'(ARM - 1)) |=> wr_en);

  a_r6_arm_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_en) |-> $past(ctl_hit && rnw && lo2[0]));

  a_r8_all_off: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_hit && lo2 == 2'b10) |=> (!rd_en && !wr_en));
endmodule

bind ovl_ram_ctrl ovl_ram_ctrl_chk #(.ARM(ARM), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rnw(rnw), .lo2(addr[1:0]), .ctl_hit(ctl_hit),
  .ram_sel(ram_sel), .ram_we(ram_we), .rom_sel(rom_sel),
  .rd_en(st.rd_en), .wr_en(st.wr_en), .cnt(cnt)
);

// File: tb/sim_ovl_ram_ctrl.sv
`timescale 1ns/1ps
module sim_ovl_ram_ctrl;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        acc_vld = 1'b0;
  logic        rnw = 1'b1;
  logic [15:0] addr = 16'h0000;
  logic        ctl_hit, ram_sel, ram_we, rom_sel;
  logic [13:0] ram_addr;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // Reference mode state
  bit m_rd = 0, m_wr = 0, m_b1 = 0;
  int m_cnt = 0;

  ovl_ram_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .rnw(rnw), .addr(addr),
    .ctl_hit(ctl_hit), .ram_sel(ram_sel), .ram_we(ram_we),
    .rom_sel(rom_sel), .ram_addr(ram_addr)
  );

  function automatic logic [17:0] exp_out(logic [15:0] a, logic r, logic v);
    logic hit, ov, rs, we, ro;
    logic [13:0] ra;
    hit = v && (a[15:4] == 12'hC08);
    ov  = v && (a >= 16'hD000);
    rs  = ov && (r ? m_rd : m_wr);
    we  = ov && !r && m_wr;
    ro  = ov && r && !m_rd;
    if (!rs)                 ra = 14'h0;
    else if (a >= 16'hE000)  ra = 14'h2000 + 14'(a - 16'hE000);
    else                     ra = (m_b1 ? 14'h0000 : 14'h1000) + 14'(a - 16'hD000);
    return {hit, rs, we, ro, ra};
  endfunction

  function automatic void upd(logic [15:0] a, logic r, logic v);
    if (!(v && a[15:4] == 12'hC08)) return;
    m_b1 = a[3];
    case (a[1:0])
      2'b00: begin m_rd = 1; m_wr = 0; m_cnt = 0; end
      2'b10: begin m_rd = 0; m_wr = 0; m_cnt = 0; end
      default: begin
        m_rd = a[1];
        if (r) begin
          if (m_cnt < 2) m_cnt++;
          if (m_cnt >= 2) m_wr = 1;
        end else m_cnt = 0;
      end
    endcase
  endfunction

  task automatic acc(string req, logic [15:0] a, logic r, logic v = 1'b1);
    logic [17:0] e, got;
    @(negedge clk);
    addr = a; rnw = r; acc_vld = v;
    #1;
    e   = exp_out(a, r, v);
    got = {ctl_hit, ram_sel, ram_we, rom_sel, ram_addr};
    n_cmp++;
    if (got !== e) begin
      n_bad++;
      $display("FAIL %s addr=%h rnw=%b vld=%b actual=%h expected=%h", req, a, r, v, got, e);
    end
    upd(a, r, v);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: reset state
    acc("R1 rom after reset", 16'hD123, 1'b1);
    acc("R1 write dropped", 16'hE000, 1'b0);
    acc("R1 upper rom", 16'hFFFC, 1'b1);

    // R12: invalid and out-of-window accesses
    acc("R12 vld low", 16'hC080, 1'b1, 1'b0);
    acc("R12 outside", 16'hC07F, 1'b1);
    acc("R2 outside above", 16'hC090, 1'b1);
    acc("R12 probe", 16'hD000, 1'b1);

    // R4 with bank 2, then R3 bank 1
    acc("R4 read-on", 16'hC080, 1'b1);
    acc("R11 bank2 read", 16'hD010, 1'b1);
    acc("R10 write dropped", 16'hD010, 1'b0);
    acc("R3 bank1 select", 16'hC088, 1'b0);
    acc("R11 bank1 read", 16'hD010, 1'b1);
    acc("R11 upper region", 16'hF000, 1'b1);

    // R6: single odd read does not arm
    acc("R6 first odd read", 16'hC081, 1'b1);
    acc("R6 not armed", 16'hD000, 1'b0);
    acc("R9 read off -> rom", 16'hD000, 1'b1);
    acc("R6 second odd read", 16'hC081, 1'b1);
    acc("R6 armed write", 16'hD000, 1'b0);
    for (int i = 0; i < 5; i++) acc("R5 saturate", 16'hC081, 1'b1);
    acc("R5 still armed", 16'hE5A5, 1'b0);

    // R7: write in between resets the count
    acc("R8 all off", 16'hC082, 1'b1);
    acc("R8 write dropped", 16'hD200, 1'b0);
    acc("R8 rom read", 16'hD200, 1'b1);
    acc("R7 odd read 1", 16'hC083, 1'b1);
    acc("R7 ctl write", 16'hC083, 1'b0);
    acc("R7 odd read 2", 16'hC083, 1'b1);
    acc("R7 not armed yet", 16'hD000, 1'b0);
    acc("R7 odd read 3", 16'hC083, 1'b1);
    acc("R7 armed", 16'hD000, 1'b0);
    acc("R7 write keeps wr", 16'hC08B, 1'b0);
    acc("R7 wr kept bank1", 16'hD7FF, 1'b0);
    acc("R9 ram read bank1", 16'hDFFF, 1'b1);
    acc("R4 write clears wr", 16'hC084, 1'b0);
    acc("R4 wr off", 16'hD000, 1'b0);

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      int sel;
      logic [15:0] a;
      sel = int'($urandom_range(0, 9));
      if (sel < 4)      a = 16'hC080 | 16'($urandom_range(0, 15));
      else if (sel < 8) a = 16'hD000 + 16'($urandom_range(0, 16'h2FFF));
      else              a = 16'($urandom_range(0, 16'hCFFF));
      acc("R11 random", a, 1'($urandom_range(0, 1)), ($urandom_range(0, 9) != 0));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule